// File: doc/BRIEF.md
# Addressable-Tap Shift Register

This block is a serial-in delay line of DEPTH stages (16 by default), each WIDTH bits wide. On each rising clock edge where the shift enable is high, a new word enters the first stage and every stored word moves one stage deeper. A run-time tap address picks which stage drives the output. The result is a pipeline delay that can be changed from one cycle to the next, from 1 to DEPTH enabled edges.

The deepest stage is always available on a separate chain output. Feeding that output into the serial input of another unit, with the same shift enable, gives delays longer than DEPTH. A parameter adds an output flip-flop after the tap selector. That flip-flop loads on enabled edges and adds one more stage of delay. The stored words are data only and have no reset.

Top module: `addr_tap_shifter`

## Requirements
- R1: On each rising edge of clk with shift_en high, ser_in is stored in stage 0 and each stage i (i ≥ 1) takes the old value of stage i-1.
- R2: With OUT_MODE = TAP_COMB, tap_out equals stage tap_sel combinationally. A word presented with shift_en high therefore appears on tap_out after tap_sel+1 enabled edges, and a change of tap_sel shows on tap_out in the same cycle.
- R3: While shift_en is low, no stage changes and ser_in has no effect. tap_out still follows tap_sel over the held contents.
- R4: chain_out always equals stage DEPTH-1, whatever tap_sel is. This is a fixed delay of DEPTH enabled edges.
- R5: When chain_out of one unit drives ser_in of a second unit and both share shift_en, tap address k on the second unit gives a delay of DEPTH+k+1 enabled edges.
- R6: With OUT_MODE = TAP_FLOP, tap_out is a register. It loads the selected stage at each enabled edge, which gives a delay of tap_sel+2, and it holds while shift_en is low.
- R7: Elaboration rejects a DEPTH that is not a power of two of at least 2, and a WIDTH below 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on the rising edge |
| shift_en | input | 1 | Clock enable; high shifts the line by one stage |
| ser_in | input | WIDTH | Word entering stage 0 |
| tap_sel | input | $clog2(DEPTH) | Run-time tap address: stage whose word drives tap_out |
| tap_out | output | WIDTH | Selected stage, combinational or registered per OUT_MODE |
| chain_out | output | WIDTH | Deepest stage, for driving the next unit's ser_in |

## Verification
Two things can happen in the same cycle: a new tap address and a shift. The bench provokes this by walking the address to a different stage on every cycle while words stream in, sometimes with the enable toggling as well. It then judges each output against a queue model of the words shifted in. The combinational tap is sampled before the edge and must show the new address over the old contents. The registered tap must capture exactly that value at the edge. The cascaded second unit and the chain output are compared against the same queue, at offsets DEPTH+k and DEPTH-1.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;

   typedef enum logic {
      TAP_COMB = 1'b0,
      TAP_FLOP = 1'b1
   } tap_mode_e;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/tapsr_chain.sv
module tapsr_chain #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         en,
   input  logic [WIDTH-1:0]             din,
   output logic [DEPTH-1:0][WIDTH-1:0]  stages
);

   logic [DEPTH-1:0][WIDTH-1:0] q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (en) q[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (en) q[i] <= q[i-1];
         end
      end
   end

   assign stages = q;

endmodule

// File: rtl/tapsr_select.sv
module tapsr_select #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 16,
   localparam int SEL_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0][WIDTH-1:0] stages,
   input  logic [SEL_W-1:0]            sel,
   output logic [WIDTH-1:0]            dout
);

   always_comb begin
      dout = stages[sel];
   end

endmodule

// File: rtl/addr_tap_shifter.sv
module addr_tap_shifter #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 16,
   parameter tapsr_pkg::tap_mode_e OUT_MODE = tapsr_pkg::TAP_COMB,
   localparam int SEL_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              shift_en,
   input  logic [WIDTH-1:0]  ser_in,
   input  logic [SEL_W-1:0]  tap_sel,
   output logic [WIDTH-1:0]  tap_out,
   output logic [WIDTH-1:0]  chain_out
);
   import tapsr_pkg::*;

   // R7: parameter legality
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("addr_tap_shifter: DEPTH must be a power of two >= 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("addr_tap_shifter: WIDTH must be at least 1");
   end

   logic [DEPTH-1:0][WIDTH-1:0] stage_q;
   logic [WIDTH-1:0]            picked;

   tapsr_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
      .clk    (clk),
      .en     (shift_en),
      .din    (ser_in),
      .stages (stage_q)
   );

   tapsr_select #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_select (
      .stages (stage_q),
      .sel    (tap_sel),
      .dout   (picked)
   );

   if (OUT_MODE == TAP_FLOP) begin : g_out_flop
      logic [WIDTH-1:0] out_q;
      always_ff @(posedge clk) begin
         if (shift_en) out_q <= picked;
      end
      assign tap_out = out_q;
   end else begin : g_out_comb
      assign tap_out = picked;
   end

   assign chain_out = stage_q[DEPTH-1];

endmodule

// File: rtl/addr_tap_shifter_chk.sv
module addr_tap_shifter_chk
   import tapsr_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int DEPTH = 16,
   parameter tap_mode_e OUT_MODE = TAP_COMB,
   localparam int SEL_W = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 2)
) (
   input logic                         clk,
   input logic                         shift_en,
   input logic [WIDTH-1:0]             ser_in,
   input logic [SEL_W-1:0]             tap_sel,
   input logic [WIDTH-1:0]             tap_out,
   input logic [WIDTH-1:0]             chain_out,
   input logic [DEPTH-1:0][WIDTH-1:0]  stage_q
);

   // Warm-up: stored words are undefined until DEPTH+1 enabled edges
   logic [CW-1:0] fill_q = '0;
   logic          live;
   assign live = (fill_q == CW'(DEPTH + 1));

   always_ff @(posedge clk) begin
      if (shift_en && !live) fill_q <= fill_q + CW'(1);
   end

   logic [DEPTH-1:0][WIDTH-1:0] stage_d;
   logic [WIDTH-1:0]            in_d;
   logic [WIDTH-1:0]            tap_prev;
   always_ff @(posedge clk) begin
      stage_d <= stage_q;
      in_d    <= ser_in;
   end
   assign tap_prev = (tap_sel == '0) ? in_d : stage_d[tap_sel - SEL_W'(1)];

   assert_head_load_R1: assert property (@(posedge clk) disable iff (!live)
      shift_en |=> stage_q[0] == $past(ser_in));

   for (genvar i = 1; i < DEPTH; i++) begin : g_shift
      assert_stage_move_R1: assert property (@(posedge clk) disable iff (!live)
         shift_en |=> stage_q[i] == $past(stage_q[i-1]));
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!live)
      !shift_en |=> $stable(stage_q));

   assert_chain_R4: assert property (@(posedge clk) disable iff (!live)
      shift_en |=> chain_out == $past(stage_q[DEPTH-2]));

   if (OUT_MODE == TAP_FLOP) begin : g_flop_chk
      assert_reg_load_R6: assert property (@(posedge clk) disable iff (!live)
         shift_en |=> tap_out == $past(stage_q[tap_sel]));
      assert_reg_hold_R6: assert property (@(posedge clk) disable iff (!live)
         !shift_en |=> $stable(tap_out));
   end else begin : g_comb_chk
      assert_tap_delay_R2: assert property (@(posedge clk) disable iff (!live)
         shift_en |=> tap_out == tap_prev);
   end

endmodule

bind addr_tap_shifter addr_tap_shifter_chk #(
   .WIDTH(WIDTH), .DEPTH(DEPTH), .OUT_MODE(OUT_MODE)
) u_chk (
   .clk       (clk),
   .shift_en  (shift_en),
   .ser_in    (ser_in),
   .tap_sel   (tap_sel),
   .tap_out   (tap_out),
   .chain_out (chain_out),
   .stage_q   (stage_q)
);

// File: tb/tb_addr_tap_shifter.sv
`timescale 1ns/1ps
module tb_addr_tap_shifter;
   import tapsr_pkg::*;

   localparam int W    = 4;
   localparam int D    = 16;
   localparam int HMAX = 40;

   logic         clk = 1'b0;
   logic         shift_en;
   logic [W-1:0] ser_in;
   logic [3:0]   tap_sel;
   logic [W-1:0] tap_c, chain_c, tap_r, chain_r, tap_n, chain_n;

   always #5 clk = ~clk;

   addr_tap_shifter #(.WIDTH(W), .DEPTH(D), .OUT_MODE(TAP_COMB)) dut (
      .clk(clk), .shift_en(shift_en), .ser_in(ser_in), .tap_sel(tap_sel),
      .tap_out(tap_c), .chain_out(chain_c));

   addr_tap_shifter #(.WIDTH(W), .DEPTH(D), .OUT_MODE(TAP_FLOP)) dut_reg (
      .clk(clk), .shift_en(shift_en), .ser_in(ser_in), .tap_sel(tap_sel),
      .tap_out(tap_r), .chain_out(chain_r));

   addr_tap_shifter #(.WIDTH(W), .DEPTH(D), .OUT_MODE(TAP_COMB)) dut_next (
      .clk(clk), .shift_en(shift_en), .ser_in(chain_c), .tap_sel(tap_sel),
      .tap_out(tap_n), .chain_out(chain_n));

   int           n_chk  = 0;
   int           n_fail = 0;
   int           npush  = 0;
   bit           done   = 0;
   logic [7:0]   seed   = 8'h5a;
   logic [W-1:0] hist [HMAX];
   logic [W-1:0] rexp;
   bit           rexp_ok = 0;

   task automatic chk(input string tg, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tg, act, exp, $time);
      end
   endtask

   // One cycle: drive at negedge, check before the edge, update model after it
   task automatic step(input string tg, input logic en, input logic [3:0] k);
      logic [W-1:0] d;
      seed = seed * 8'd5 + 8'd3;
      d = seed[7:4] ^ seed[3:0];
      shift_en = en;
      ser_in   = d;
      tap_sel  = k;
      #1;
      if (npush > int'(k))      chk(tg,   tap_c,   hist[k]);
      if (npush > D - 1)        chk("R4", chain_c, hist[D-1]);
      if (npush > D + int'(k))  chk("R5", tap_n,   hist[D + int'(k)]);
      if (rexp_ok)              chk("R6", tap_r,   rexp);
      @(posedge clk);
      if (en) begin
         rexp_ok = (npush > int'(k));
         rexp    = hist[k];
         for (int i = HMAX - 1; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = d;
         npush++;
      end
      @(negedge clk);
   endtask

   task automatic t_prime();
      for (int i = 0; i < HMAX; i++) step("R1", 1'b1, 4'(i));
   endtask

   // R1/R2: every address held steady under a stream
   task automatic t_sweep();
      for (int k = 0; k < D; k++)
         for (int i = 0; i < 20; i++) step("R1", 1'b1, 4'(k));
   endtask

   // R2: address changes every cycle while shifting
   task automatic t_addr_walk();
      for (int i = 0; i < 64; i++) step("R2", 1'b1, 4'((i * 7 + 3) % D));
   endtask

   // R3/R6: enable low with moving address and data, then mixed enables
   task automatic t_hold();
      for (int i = 0; i < 16; i++) step("R3", 1'b0, 4'(15 - i));
      for (int i = 0; i < 48; i++) step("R3", (i % 3) != 0, 4'((i * 5) % D));
   endtask

   // R5: deep taps on the cascaded pair
   task automatic t_cascade();
      for (int i = 0; i < 40; i++) step("R5", 1'b1, 4'(15 - (i % 4)));
   endtask

   initial begin
      shift_en = 1'b0;
      ser_in   = '0;
      tap_sel  = '0;
      @(negedge clk);
      @(negedge clk);
      t_prime();
      t_sweep();
      t_addr_walk();
      t_hold();
      t_cascade();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all R): actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule